// File: doc/BRIEF.md
# Systolic Linear-Phase FIR Filter

This block filters a stream of signed samples with a linear-phase (mirror-symmetric) impulse response. It accepts one sample on every clock. Each of its stages adds the two delay-line samples that share a coefficient, multiplies that sum by the coefficient, and adds the product into a registered adder chain. The last register of the chain drives the output. Because the coefficients are mirrored, the block needs only half as many multipliers as there are taps.

The coefficients are fixed at elaboration through a packed parameter vector. A parameter option gives an odd tap count, in which the last stage becomes a single centre tap. The block makes no rate change and applies no gain. The output carries the full-precision sum, and out_valid follows the input strobe through the same fixed pipeline delay. A clock with in_valid low enters the filter as a zero sample, so every output keeps its fixed timing.

Top module: `sym_fir_systolic`

## Requirements
- R1: With S = NUM_STAGES, N = 2·S taps and L = S+3, out_data in cycle n equals the exact two's-complement sum over k = 0..N−1 of h_k·s(n−L−k). Here s(m) is the sample entered in cycle m, h_k is coefficient K_k for k < S and K_(N−1−k) otherwise, and K_i is slice COEF_VEC[i·COEF_W +: COEF_W], read as signed.
- R2: A single non-zero sample followed by idle cycles produces the impulse response. out_data first becomes non-zero L cycles after the sample is presented, then steps through h_0·x … h_(N−1)·x and returns to zero.
- R3: out_valid in cycle n equals the in_valid presented in cycle n−L.
- R4: A cycle with in_valid low enters the delay line as a zero sample, whatever value in_data carries.
- R5: rst_n is synchronous and active low. It clears the delay line, the pre-adder, product and chain registers and the valid pipeline, so out_data and out_valid stay zero for the first L cycles after release. A reset in the middle of a stream discards all earlier history.
- R6: Full-scale samples (−2^(DATA_W−1) and 2^(DATA_W−1)−1) combined with coefficients that include −2^(COEF_W−1) give exact results with no wrap in the OUT_W-bit output.
- R7: With ODD_LEN = 1 the tap count is N = 2·S−1. K_(S−1) becomes the single centre tap h_(S−1), and the remaining taps mirror as in R1 (h_k = K_(N−1−k) for k ≥ S).
- R8: The filter takes a new valid sample on every clock, with no stall and no gap in its output stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks in_data as a real sample; low enters a zero sample |
| in_data | input | DATA_W | Signed input sample, at most 17 bits |
| out_valid | output | 1 | in_valid delayed by the pipeline latency |
| out_data | output | OUT_W | Signed full-precision filter output |

## Verification
Two situations are hard to reach from the ports. The first is a reset that lands while the pipeline is full of non-zero partial sums. The second is the mirrored pair alignment, which only shows when the forward and reverse taps hold different, large values. The stimulus therefore asserts reset in the middle of a dense random stream while in_valid stays high and in_data carries large values, and then checks that the output restarts from a clean history. It also drives blocks of full-scale and alternating-sign samples, and gap patterns in which in_data carries junk while in_valid is low. An even-length and an odd-length instance run side by side on the same stream, so a mistake in the centre-tap variant or the mirror indexing shows up as a per-cycle mismatch.

// File: rtl/sfir_pkg.sv
package sfir_pkg;
   timeunit 1ns;
   timeprecision 1ps;

   // Width that holds an exact sum of n_stages products of a pre-added
   // sample pair and a coefficient.
   function automatic int full_out_w(input int data_w, input int coef_w, input int n_stages);
      return data_w + 1 + coef_w + ((n_stages > 1) ? $clog2(n_stages) : 0);
   endfunction

   // Number of filter taps served by n_stages coefficient stages.
   function automatic int tap_count(input int n_stages, input bit odd_len);
      return 2 * n_stages - (odd_len ? 1 : 0);
   endfunction

   // Fixed pipeline depth: delay-line entry, pre-add, product, then one
   // chain register per stage.
   function automatic int pipe_latency(input int n_stages);
      return n_stages + 3;
   endfunction
endpackage

// File: rtl/sfir_tapline.sv
module sfir_tapline #(
   parameter int DATA_W = 17,
   parameter int DEPTH  = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          in_valid,
   input  logic signed [DATA_W-1:0]      in_data,
   output logic [DEPTH-1:0][DATA_W-1:0]  taps
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DATA_W-1:0] entry;

   // A cycle without a strobe is a zero sample, so timing never shifts.
   assign entry = in_valid ? in_data : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         taps <= '0;
      end else begin
         taps[0] <= entry;
         for (int k = 1; k < DEPTH; k++) begin
            taps[k] <= taps[k-1];
         end
      end
   end
endmodule

// File: rtl/sfir_stage.sv
module sfir_stage #(
   parameter int                        DATA_W = 17,
   parameter int                        COEF_W = 18,
   parameter int                        OUT_W  = 38,
   parameter logic signed [COEF_W-1:0]  COEF   = '0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic signed [DATA_W-1:0] fwd_tap,
   input  logic signed [DATA_W-1:0] rev_tap,
   input  logic signed [OUT_W-1:0]  sum_in,
   output logic signed [OUT_W-1:0]  sum_out
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int PRE_W  = DATA_W + 1;
   localparam int PROD_W = PRE_W + COEF_W;

   logic signed [PRE_W-1:0]  pre_q;
   logic signed [PROD_W-1:0] prod_q;
   logic signed [OUT_W-1:0]  prod_wide;

   assign prod_wide = OUT_W'(prod_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q   <= '0;
         prod_q  <= '0;
         sum_out <= '0;
      end else begin
         pre_q   <= PRE_W'(fwd_tap) + PRE_W'(rev_tap);
         prod_q  <= PROD_W'(pre_q) * PROD_W'(COEF);
         sum_out <= sum_in + prod_wide;
      end
   end
endmodule

// File: rtl/sfir_valid_pipe.sv
module sfir_valid_pipe #(
   parameter int DEPTH = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   output logic out_valid
);
   timeunit 1ns;
   timeprecision 1ps;

   logic [DEPTH-1:0] stages_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stages_q <= '0;
      end else begin
         stages_q <= {stages_q[DEPTH-2:0], in_valid};
      end
   end

   assign out_valid = stages_q[DEPTH-1];
endmodule

// File: rtl/sym_fir_systolic.sv
module sym_fir_systolic
   import sfir_pkg::*;
#(
   parameter int DATA_W     = 17,
   parameter int COEF_W     = 18,
   parameter int NUM_STAGES = 4,
   parameter int OUT_W      = 38,
   parameter bit ODD_LEN    = 1'b0,
   parameter logic [NUM_STAGES*COEF_W-1:0] COEF_VEC =
      {18'h20000, 18'h0162E, 18'h3FB2E, 18'h1FFFF}
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     in_valid,
   input  logic signed [DATA_W-1:0] in_data,
   output logic                     out_valid,
   output logic signed [OUT_W-1:0]  out_data
);
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NUM_TAPS   = tap_count(NUM_STAGES, ODD_LEN);
   localparam int LATENCY    = pipe_latency(NUM_STAGES);
   localparam int NEED_W     = full_out_w(DATA_W, COEF_W, NUM_STAGES);
   localparam int QUIET_SPAN = LATENCY + NUM_TAPS - 1;
   localparam int RUN_W      = $clog2(QUIET_SPAN + 1) + 1;
   localparam logic [RUN_W-1:0] LAT_C  = RUN_W'(LATENCY);
   localparam logic [RUN_W-1:0] SPAN_C = RUN_W'(QUIET_SPAN);

   // ---------------- elaboration checks ----------------
   if (DATA_W < 2 || DATA_W > 17) begin : g_chk_data
      $error("sym_fir_systolic: DATA_W must lie in 2..17 so the pre-add fits 18 bits");
   end
   if (COEF_W < 2 || COEF_W > 18) begin : g_chk_coef
      $error("sym_fir_systolic: COEF_W must lie in 2..18");
   end
   if (NUM_STAGES < 1) begin : g_chk_stages
      $error("sym_fir_systolic: NUM_STAGES must be at least 1");
   end
   if (OUT_W < NEED_W) begin : g_chk_out
      $error("sym_fir_systolic: OUT_W is below the full-precision width");
   end

   // ---------------- sample delay line ----------------
   logic [NUM_TAPS-1:0][DATA_W-1:0] taps;

   sfir_tapline #(
      .DATA_W (DATA_W),
      .DEPTH  (NUM_TAPS)
   ) u_taps (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_data  (in_data),
      .taps     (taps)
   );

   // ---------------- stages and adder chain ----------------
   // Stage i reads forward tap 2*i; every paired stage reads the last tap
   // as its mirror partner, which the chain delay brings into line.
   logic signed [OUT_W-1:0] chain [NUM_STAGES+1];
   assign chain[0] = '0;

   for (genvar i = 0; i < NUM_STAGES; i++) begin : g_stage
      logic signed [DATA_W-1:0] fwd_sel;
      logic signed [DATA_W-1:0] rev_sel;

      assign fwd_sel = $signed(taps[2*i]);

      if (ODD_LEN && (i == NUM_STAGES - 1)) begin : g_centre
         assign rev_sel = '0;
      end else begin : g_pair
         assign rev_sel = $signed(taps[NUM_TAPS-1]);
      end

      sfir_stage #(
         .DATA_W (DATA_W),
         .COEF_W (COEF_W),
         .OUT_W  (OUT_W),
         .COEF   ($signed(COEF_VEC[i*COEF_W +: COEF_W]))
      ) u_stage (
         .clk     (clk),
         .rst_n   (rst_n),
         .fwd_tap (fwd_sel),
         .rev_tap (rev_sel),
         .sum_in  (chain[i]),
         .sum_out (chain[i+1])
      );
   end

   assign out_data = chain[NUM_STAGES];

   // ---------------- valid strobe ----------------
   sfir_valid_pipe #(
      .DEPTH (LATENCY)
   ) u_valid (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .out_valid (out_valid)
   );

   // ---------------- assertion support counters ----------------
   logic [RUN_W-1:0] idle_run;
   logic [RUN_W-1:0] busy_run;
   logic [RUN_W-1:0] since_rst;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idle_run  <= SPAN_C;
         busy_run  <= '0;
         since_rst <= '0;
      end else begin
         if (in_valid)            idle_run <= '0;
         else if (idle_run < SPAN_C) idle_run <= idle_run + 1'b1;

         if (!in_valid)           busy_run <= '0;
         else if (busy_run < LAT_C) busy_run <= busy_run + 1'b1;

         if (since_rst < LAT_C)   since_rst <= since_rst + 1'b1;
      end
   end

   // R5: nothing emerges during the first LATENCY cycles after reset
   a_r5_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < LAT_C) |-> (!out_valid && out_data == '0));

   // R4: once the whole window holds only gap cycles the output is zero
   a_r4_gaps_give_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_run >= SPAN_C) |-> (out_data == '0));

   // R3: a run of idle inputs at least LATENCY long silences out_valid
   a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (idle_run >= LAT_C) |-> !out_valid);

   // R8: a run of strobes at least LATENCY long keeps out_valid high
   a_r8_stream_valid: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_run >= LAT_C) |-> out_valid);
endmodule

// File: tb/sym_fir_systolic_test.sv
module sym_fir_systolic_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int DW  = 17;
   localparam int CW  = 18;
   localparam int NS  = 4;
   localparam int OW  = 38;
   localparam int LAT = NS + 3;
   localparam logic [NS*CW-1:0] CVEC = {18'h20000, 18'h0162E, 18'h3FB2E, 18'h1FFFF};
   localparam int HMAX = 4096;

   // coefficient values K0..K3 as the requirements define them
   longint kc [NS] = '{131071, -1234, 5678, -131072};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic signed [DW-1:0] in_data = '0;
   logic out_valid, odd_valid;
   logic signed [OW-1:0] out_data, odd_data;

   always #10 clk = ~clk;

   sym_fir_systolic #(
      .DATA_W(DW), .COEF_W(CW), .NUM_STAGES(NS), .OUT_W(OW),
      .ODD_LEN(1'b0), .COEF_VEC(CVEC)
   ) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(out_valid), .out_data(out_data)
   );

   sym_fir_systolic #(
      .DATA_W(DW), .COEF_W(CW), .NUM_STAGES(NS), .OUT_W(OW),
      .ODD_LEN(1'b1), .COEF_VEC(CVEC)
   ) uut_odd (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .out_valid(odd_valid), .out_data(odd_data)
   );

   longint s_hist [HMAX];
   bit     v_hist [HMAX];
   int     cyc      = 0;
   int     floor_c  = 0;
   int     n_checks = 0;
   int     n_fails  = 0;
   string  cur_tag  = "R5";
   bit     done     = 1'b0;

   function automatic longint model_out(input int c, input bit odd);
      int n = odd ? 2*NS - 1 : 2*NS;
      longint acc = 0;
      for (int k = 0; k < n; k++) begin
         int idx = c - LAT - k;
         int j = (k < NS) ? k : n - 1 - k;
         if (idx >= floor_c) acc += kc[j] * s_hist[idx];
      end
      return acc;
   endfunction

   function automatic bit model_valid(input int c);
      int idx = c - LAT;
      return (idx >= floor_c) ? v_hist[idx] : 1'b0;
   endfunction

   function automatic longint rnd_sample();
      logic signed [DW-1:0] r;
      r = DW'($urandom);
      return longint'(r);
   endfunction

   task automatic compare(input string tag, input string what, input longint act, input longint exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
      end
   endtask

   task automatic check_now();
      compare(cur_tag, "even-length data", longint'(out_data), model_out(cyc, 1'b0));
      compare("R3", "even-length valid", longint'(out_valid), longint'(model_valid(cyc)));
      compare("R7", "odd-length data", longint'(odd_data), model_out(cyc, 1'b1));
      compare("R3", "odd-length valid", longint'(odd_valid), longint'(model_valid(cyc)));
   endtask

   // One normal cycle: check, then present the next input.
   task automatic step(input bit v, input longint d);
      @(negedge clk);
      check_now();
      rst_n    = 1'b1;
      in_valid = v;
      in_data  = v ? DW'(d) : DW'($urandom);   // junk on gaps (R4)
      s_hist[cyc] = v ? longint'($signed(in_data)) : 0;
      v_hist[cyc] = v;
      cyc++;
   endtask

   // One cycle with reset held: busy-looking input must be discarded.
   task automatic reset_cycle();
      @(negedge clk);
      check_now();
      rst_n    = 1'b0;
      in_valid = 1'b1;
      in_data  = DW'($urandom);
      s_hist[cyc] = 0;
      v_hist[cyc] = 1'b0;
      floor_c = cyc + 1;
      cyc++;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      void'($urandom(32'd917));
      // R5: initial reset, then data straight away
      cur_tag = "R5";
      for (int i = 0; i < 4; i++) reset_cycle();
      for (int i = 0; i < LAT + 4; i++) step(1'b1, rnd_sample());
      for (int i = 0; i < 20; i++) step(1'b0, 0);

      // R2: impulse responses of two amplitudes
      cur_tag = "R2";
      step(1'b1, 1);
      for (int i = 0; i < 16; i++) step(1'b0, 0);
      step(1'b1, -3);
      for (int i = 0; i < 16; i++) step(1'b0, 0);

      // R6: full-scale blocks
      cur_tag = "R6";
      for (int i = 0; i < 20; i++) step(1'b1, 65535);
      for (int i = 0; i < 20; i++) step(1'b1, -65536);
      for (int i = 0; i < 24; i++) step(1'b1, (i % 2 == 0) ? -65536 : 65535);
      for (int i = 0; i < 24; i++) step(1'b1, ((i / 4) % 2 == 0) ? -65536 : 65535);

      // R8: unbroken random stream
      cur_tag = "R8";
      for (int i = 0; i < 300; i++) step(1'b1, rnd_sample());

      // R4: sparse strobes with junk data in the gaps
      cur_tag = "R4";
      for (int i = 0; i < 300; i++) step(($urandom % 2) == 0, rnd_sample());

      // R1: mostly dense random stream
      cur_tag = "R1";
      for (int i = 0; i < 300; i++) step(($urandom % 8) != 0, rnd_sample());

      // R5: reset in the middle of a dense stream
      cur_tag = "R5";
      reset_cycle();
      reset_cycle();
      for (int i = 0; i < LAT + 12; i++) step(1'b1, rnd_sample());

      cur_tag = "R4";
      for (int i = 0; i < 20; i++) step(1'b0, 0);
      @(negedge clk);
      check_now();
      finish_run();
   end
endmodule